// File: doc/BRIEF.md
# Four-Phase Bundled-Data Pipeline Stage Controller

This block is the control unit of one stage in a self-timed pipeline. It handles three handshakes. The upstream channel gives a request and takes an acknowledge, with the data bundled beside the request. The local datapath takes a start and gives a done, and its done comes from ordinary single-rail logic behind a delay matched to that logic and launched by start. The downstream channel takes a request and gives an acknowledge. All three use four-phase return-to-zero signalling. The controller is a synchronous state machine that samples the handshake wires on a clock. This lets the exact order of events be checked cycle by cycle.

In the set half, start follows the incoming request. The outgoing request follows done, and the upstream acknowledge follows the downstream acknowledge. The reset half returns every wire to zero in the same order: request falls, start falls, done falls, outgoing request falls, downstream acknowledge falls, upstream acknowledge falls. Incoming data is registered only when the request is seen high, because the data wires may glitch at any other time. The datapath result is registered when done is seen high. A handshake input that is out of order raises an error flag, and the controller does not advance.

Top module: `hs_stage_ctrl`

## Requirements
- R1: In the first cycle after synchronous reset is released, dp_start, out_req, in_ack and proto_err are 0, and dp_operand and out_data are all zeros.
- R2: In the idle state (all three control outputs low), in_req sampled high with dp_done and out_ack low raises dp_start one cycle later. dp_operand then takes the in_data value sampled at that same edge.
- R3: While only dp_start is high, dp_done sampled high with in_req high and out_ack low raises out_req one cycle later, with dp_start still high. out_data then takes the dp_result value sampled at that edge.
- R4: With dp_start and out_req high and in_ack low, out_ack sampled high (in_req and dp_done high) raises in_ack one cycle later.
- R5: With all three outputs high, in_req sampled low (dp_done and out_ack high) lowers dp_start one cycle later. out_req and in_ack stay high.
- R6: With out_req and in_ack high and dp_start low, dp_done sampled low (in_req low, out_ack high) lowers out_req one cycle later.
- R7: With only in_ack high, out_ack sampled low (in_req and dp_done low) lowers in_ack one cycle later, which returns the stage to idle. A new cycle may then start.
- R8: dp_operand changes only on the edge named in R2, and out_data changes only on the edge named in R3. Changes on in_data or dp_result at any other time have no effect. out_data therefore stays stable from the rise of out_req until the next result capture, which is after in_ack has fallen.
- R9: A handshake input that leaves its required level is a protocol error. proto_err is 1 in the cycle after each sampled error, and the control outputs and both data registers keep their values. The required levels for each output pattern (dp_start, out_req, in_ack) are: 000 needs dp_done=0 and out_ack=0; 100 needs in_req=1 and out_ack=0; 110 needs in_req=1 and dp_done=1; 111 needs dp_done=1 and out_ack=1; 011 needs in_req=0 and out_ack=1; 001 needs in_req=0 and dp_done=0.
- R10: When a protocol error and the expected advancing event are sampled at the same edge, the error wins. The stage does not advance and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | 1 | Upstream request, marks in_data as valid |
| in_data | input | DATA_W | Upstream bundled data |
| in_ack | output | 1 | Upstream acknowledge |
| dp_operand | output | DATA_W | Captured operand presented to the datapath |
| dp_start | output | 1 | Launches the datapath and its matched delay |
| dp_done | input | 1 | Matched-delay completion from the datapath |
| dp_result | input | DATA_W | Datapath result |
| out_req | output | 1 | Downstream request, marks out_data as valid |
| out_ack | input | 1 | Downstream acknowledge |
| out_data | output | DATA_W | Captured result held for downstream |
| proto_err | output | 1 | Out-of-order handshake seen in the previous cycle |

## Verification
The stage is driven by a partner model that moves each expected event after a random delay. This shows whether each output waits for its own trigger rather than firing early or stalling. Data inputs change every cycle, so a capture at the wrong edge shows as a wrong operand or result value. At random, a wire that must stay at its level is flipped, sometimes in the same cycle as the legal event. This separates a correct freeze with an error flag from a stage that advances or captures anyway. A directed case raises the downstream acknowledge together with the request while idle, and the random run must finish many complete cycles.

// File: rtl/hs_stage_pkg.sv
package hs_stage_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_BUSY    = 3'd1,
        PH_OFFER   = 3'd2,
        PH_GRANT   = 3'd3,
        PH_DRAIN   = 3'd4,
        PH_RELEASE = 3'd5
    } phase_e;

    typedef struct packed {
        logic req;
        logic done;
        logic ack;
    } hs_in_t;

    typedef struct packed {
        logic start;
        logic oreq;
        logic iack;
    } hs_out_t;

    function automatic hs_out_t drive_of(phase_e p);
        hs_out_t o;
        o = '0;
        case (p)
            PH_BUSY:    o = '{start: 1'b1, oreq: 1'b0, iack: 1'b0};
            PH_OFFER:   o = '{start: 1'b1, oreq: 1'b1, iack: 1'b0};
            PH_GRANT:   o = '{start: 1'b1, oreq: 1'b1, iack: 1'b1};
            PH_DRAIN:   o = '{start: 1'b0, oreq: 1'b1, iack: 1'b1};
            PH_RELEASE: o = '{start: 1'b0, oreq: 1'b0, iack: 1'b1};
            default:    o = '0;
        endcase
        return o;
    endfunction

    // Inputs that must hold a level while another event is awaited.
    function automatic logic order_fault(phase_e p, hs_in_t i);
        case (p)
            PH_IDLE:    return i.done | i.ack;
            PH_BUSY:    return ~i.req | i.ack;
            PH_OFFER:   return ~i.req | ~i.done;
            PH_GRANT:   return ~i.done | ~i.ack;
            PH_DRAIN:   return i.req | ~i.ack;
            PH_RELEASE: return i.req | i.done;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic event_seen(phase_e p, hs_in_t i);
        case (p)
            PH_IDLE:    return i.req;
            PH_BUSY:    return i.done;
            PH_OFFER:   return i.ack;
            PH_GRANT:   return ~i.req;
            PH_DRAIN:   return ~i.done;
            PH_RELEASE: return ~i.ack;
            default:    return 1'b1;
        endcase
    endfunction

    function automatic phase_e next_of(phase_e p);
        case (p)
            PH_IDLE:  return PH_BUSY;
            PH_BUSY:  return PH_OFFER;
            PH_OFFER: return PH_GRANT;
            PH_GRANT: return PH_DRAIN;
            PH_DRAIN: return PH_RELEASE;
            default:  return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/hs_hold_reg.sv
module hs_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/hs_stage_fsm.sv
module hs_stage_fsm
    import hs_stage_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  hs_in_t  ins,
    output hs_out_t outs,
    output logic    cap_operand,
    output logic    cap_result,
    output logic    fault_q
);
    phase_e ph_q, ph_d;
    logic   fault, step;

    always_comb begin
        fault = order_fault(ph_q, ins);
        step  = !fault && event_seen(ph_q, ins);
        ph_d  = step ? next_of(ph_q) : ph_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            fault_q <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            fault_q <= fault;
        end
    end

    assign outs        = drive_of(ph_q);
    assign cap_operand = step && (ph_q == PH_IDLE);
    assign cap_result  = step && (ph_q == PH_BUSY);

    AST_START_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.start) |-> $past(ins.req)); // R2
    AST_OREQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.oreq) |-> $past(ins.done) && outs.start); // R3
    AST_IACK_AFTER_OACK: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.iack) |-> $past(ins.ack) && outs.oreq); // R4
    AST_START_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.start) |-> !$past(ins.req) && outs.oreq && outs.iack); // R5
    AST_OREQ_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.oreq) |-> !$past(ins.done) && !outs.start); // R6
    AST_IACK_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.iack) |-> !$past(ins.ack) && !outs.oreq); // R7
    AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> $stable(outs)); // R9
endmodule

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl
    import hs_stage_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_req,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ack,
    output logic [DATA_W-1:0] dp_operand,
    output logic              dp_start,
    input  logic              dp_done,
    input  logic [DATA_W-1:0] dp_result,
    output logic              out_req,
    input  logic              out_ack,
    output logic [DATA_W-1:0] out_data,
    output logic              proto_err
);
    hs_in_t  ins;
    hs_out_t outs;
    logic    cap_operand, cap_result;

    assign ins = '{req: in_req, done: dp_done, ack: out_ack};

    hs_stage_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ins         (ins),
        .outs        (outs),
        .cap_operand (cap_operand),
        .cap_result  (cap_result),
        .fault_q     (proto_err)
    );

    hs_hold_reg #(.WIDTH(DATA_W)) u_operand_reg (
        .clk  (clk),
        .rst  (rst),
        .load (cap_operand),
        .d    (in_data),
        .q    (dp_operand)
    );

    hs_hold_reg #(.WIDTH(DATA_W)) u_result_reg (
        .clk  (clk),
        .rst  (rst),
        .load (cap_result),
        .d    (dp_result),
        .q    (out_data)
    );

    assign dp_start = outs.start;
    assign out_req  = outs.oreq;
    assign in_ack   = outs.iack;

    AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (rst)
        (dp_start && $past(dp_start)) |-> $stable(dp_operand)); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        ((out_req || in_ack) && $past(out_req || in_ack)) |-> $stable(out_data)); // R8
    AST_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $stable(dp_operand) && $stable(out_data)); // R9
endmodule

// File: tb/hs_stage_ctrl_bench.sv
module hs_stage_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int N_CYC      = 4000;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_req, dp_done, out_ack;
    logic [W-1:0] in_data, dp_result;
    logic         in_ack, dp_start, out_req, proto_err;
    logic [W-1:0] dp_operand, out_data;

    hs_stage_ctrl #(.DATA_W(W)) u_hs_stage_ctrl (
        .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data), .in_ack(in_ack),
        .dp_operand(dp_operand), .dp_start(dp_start), .dp_done(dp_done),
        .dp_result(dp_result), .out_req(out_req), .out_ack(out_ack),
        .out_data(out_data), .proto_err(proto_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int           n_run = 0, n_fail = 0, laps = 0, ph = 0;
    logic [W-1:0] e_op = '0, e_out = '0;
    logic         e_err = 1'b0;
    bit           finished = 0;

    function automatic logic f_bad(int p, logic r, logic d, logic a);
        case (p)
            0: return d | a;
            1: return !r | a;
            2: return !r | !d;
            3: return !d | !a;
            4: return r | !a;
            default: return r | d;
        endcase
    endfunction

    function automatic logic f_go(int p, logic r, logic d, logic a);
        case (p)
            0: return r;
            1: return d;
            2: return a;
            3: return !r;
            4: return !d;
            default: return !a;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model of the next clock edge, from the input values now driven.
    task automatic model_edge();
        logic bad;
        bad   = f_bad(ph, in_req, dp_done, out_ack);
        e_err = bad;
        if (!bad && f_go(ph, in_req, dp_done, out_ack)) begin
            if (ph == 0) e_op  = in_data;
            if (ph == 1) e_out = dp_result;
            ph = (ph + 1) % 6;
            if (ph == 0) laps++;
        end
    endtask

    task automatic check_all();
        chk("R2 R5 dp_start", dp_start, (ph >= 1 && ph <= 3));
        chk("R3 R6 out_req",  out_req,  (ph >= 2 && ph <= 4));
        chk("R4 R7 in_ack",   in_ack,   (ph >= 3 && ph <= 5));
        chk("R2 R8 dp_operand", dp_operand, e_op);
        chk("R3 R8 out_data",   out_data,   e_out);
        chk("R9 R10 proto_err", proto_err,  e_err);
    endtask

    // Partner: hold the levels this phase requires, maybe fire the event, maybe break a level.
    task automatic drive_partner();
        int pick;
        case (ph)
            0: begin dp_done = 0; out_ack = 0; end
            1: begin in_req = 1;  out_ack = 0; end
            2: begin in_req = 1;  dp_done = 1; end
            3: begin dp_done = 1; out_ack = 1; end
            4: begin in_req = 0;  out_ack = 1; end
            default: begin in_req = 0; dp_done = 0; end
        endcase
        if ($urandom % 2 == 0) begin
            case (ph)
                0: in_req = 1;
                1: dp_done = 1;
                2: out_ack = 1;
                3: in_req = 0;
                4: dp_done = 0;
                default: out_ack = 0;
            endcase
        end
        if ($urandom % 20 == 0) begin
            pick = int'($urandom % 2);
            case (ph)
                0: if (pick == 0) dp_done = ~dp_done; else out_ack = ~out_ack;
                1: if (pick == 0) in_req  = ~in_req;  else out_ack = ~out_ack;
                2: if (pick == 0) in_req  = ~in_req;  else dp_done = ~dp_done;
                3: if (pick == 0) dp_done = ~dp_done; else out_ack = ~out_ack;
                4: if (pick == 0) in_req  = ~in_req;  else out_ack = ~out_ack;
                default: if (pick == 0) in_req = ~in_req; else dp_done = ~dp_done;
            endcase
        end
        in_data   = W'($urandom);
        dp_result = W'($urandom);
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        rst = 1; in_req = 0; dp_done = 0; out_ack = 0; in_data = '0; dp_result = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        in_data = 8'hA5;
        @(negedge clk);
        // R1: reset state
        chk("R1 dp_start",  dp_start,  0);
        chk("R1 out_req",   out_req,   0);
        chk("R1 in_ack",    in_ack,    0);
        chk("R1 proto_err", proto_err, 0);
        chk("R1 dp_operand", dp_operand, 0);
        chk("R1 out_data",   out_data,   0);

        // R9 R10: downstream ack together with request while idle
        in_req = 1; out_ack = 1; in_data = 8'h3C;
        model_edge();
        @(negedge clk);
        chk("R9 R10 err flagged", proto_err, 1);
        chk("R10 no start on fault", dp_start, 0);
        chk("R10 operand not captured", dp_operand, 0);
        in_req = 0; out_ack = 0;
        model_edge();
        @(negedge clk);
        chk("R9 err cleared", proto_err, 0);

        for (int i = 0; i < N_CYC; i++) begin
            drive_partner();
            model_edge();
            @(negedge clk);
            check_all();
        end
        chk("R7 completed laps", (laps >= 50), 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", laps, N_CYC);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule